// File: doc/BRIEF.md
# Timer Count-Clock Source Selector

This block decides when an 8-bit timer/event counter advances. Every cycle of the peripheral clock it may raise a one-cycle count-enable. The enable comes from one of eight sources. Two of them follow the external event pin: one fires on its falling edges, the other on its rising edges. The other six are taps of a free-running power-of-two prescaler. The output is always a plain enable in the peripheral clock domain, never a derived clock. The counter it feeds, the compare logic and the pin direction control live elsewhere.

Software picks the source through an 8-bit control register. It can write the whole byte, or set or clear a single bit. Only the low three bits hold state; the upper five always read zero. The timer owner drives a run flag. While that flag is high, any attempt to change the source is dropped and a sticky error flag is raised. The external pin is re-timed by two flops and then compared with its previous sample to find edges.

Top module: `tmr_cntclk_sel`

## Requirements
- R1: After reset, `ctl_rdata` is 00H (falling-edge source), `cfg_err` is 0 and the prescaler starts from zero.
- R2: A byte write (`ctl_wr`) while `run` is low loads `ctl_wdata[2:0]` into the select field; bits 7..3 of `ctl_rdata` always read 0 whatever was written.
- R3: A bit write (`bit_wr`) while `run` is low sets bit `bit_idx` of the register to `bit_val` when `bit_idx` is 0, 1 or 2, and changes nothing when `bit_idx` is 3 to 7.
- R4: While `run` is high, a byte write or a bit write aimed at bits 0..2 leaves the select field unchanged and sets `cfg_err`. `cfg_err` stays set until reset. A bit write to bits 3..7 while running does not set it.
- R5: Select 000: one count pulse per falling edge of `evt_in`. With the pin changed before clock edge k, the pulse is high in the cycle that follows edge k+1.
- R6: Select 001: one count pulse per rising edge of `evt_in`, with the same latency as R5.
- R7: Select 010 enables every cycle. Select 011 enables every 2nd cycle.
- R8: Selects 100, 101, 110 and 111 enable once every 2^LG_D4, 2^LG_D5, 2^LG_D6 and 2^LG_D7 cycles (by default 4, 64, 256 and 8192). Any window whose length is a multiple of the period holds exactly one pulse per period.
- R9: Except under select 010, `cnt_en` is never high in two consecutive cycles while the select field is unchanged.
- R10: When a byte write and a bit write arrive in the same cycle, only the byte write takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run | input | 1 | Timer running; locks the select field |
| ctl_wr | input | 1 | Full-byte register write strobe |
| ctl_wdata | input | 8 | Byte write data |
| bit_wr | input | 1 | Single-bit write strobe |
| bit_idx | input | 3 | Bit position for a single-bit write |
| bit_val | input | 1 | Value for a single-bit write |
| evt_in | input | 1 | External event pin (asynchronous) |
| ctl_rdata | output | 8 | Control register read value |
| cfg_err | output | 1 | Sticky flag: source change tried while running |
| cnt_en | output | 1 | One-cycle count enable to the timer |

## Verification
The bench builds the block with a 10-bit prescaler and tap exponents 2, 5, 7 and 10. This shrinks the slowest period from 8192 to 1024 cycles. With that, every select value can be counted over several full periods, and all 256 byte values and all 128 bit-write combinations can be swept quickly. The edge sources are driven with runs of toggles, and the exact pulse cycle after a pin change is checked. The lock is tested on both kinds of write, and on reserved-bit writes while running.

// File: rtl/tmr_cntclk_sel.sv
module tmr_cntclk_sel #(
  parameter int PRE_W = 13,
  parameter int LG_D4 = 2,
  parameter int LG_D5 = 6,
  parameter int LG_D6 = 8,
  parameter int LG_D7 = 13
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic       ctl_wr,
  input  logic [7:0] ctl_wdata,
  input  logic       bit_wr,
  input  logic [2:0] bit_idx,
  input  logic       bit_val,
  input  logic       evt_in,
  output logic [7:0] ctl_rdata,
  output logic       cfg_err,
  output logic       cnt_en
);

  localparam int NTAP = 6;
  localparam int LG [NTAP] = '{0, 1, LG_D4, LG_D5, LG_D6, LG_D7};

  logic [2:0]       sel;
  logic [PRE_W-1:0] pre;
  logic             s1, s2, s3;
  logic [7:0]       src;

  wire       bit_low = (bit_idx < 3'd3);
  wire       wr_sel  = ctl_wr | (bit_wr & bit_low);
  wire [2:0] bmask   = 3'(3'd1 << bit_idx[1:0]);
  wire [2:0] bit_nxt = bit_val ? (sel | bmask) : (sel & ~bmask);

  logic unused_hi;
  assign unused_hi = &{1'b0, ctl_wdata[7:3]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel     <= '0;
      cfg_err <= 1'b0;
    end else if (wr_sel) begin
      if (run)         cfg_err <= 1'b1;
      else if (ctl_wr) sel     <= ctl_wdata[2:0];
      else             sel     <= bit_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre <= '0;
    else        pre <= pre + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) {s1, s2, s3} <= '0;
    else        {s1, s2, s3} <= {evt_in, s1, s2};
  end

  assign src[0] = ~s2 & s3;
  assign src[1] = s2 & ~s3;

  for (genvar i = 0; i < NTAP; i++) begin : g_tap
    localparam logic [PRE_W-1:0] MASK = PRE_W'((64'd1 << LG[i]) - 64'd1);
    assign src[i+2] = &(pre | ~MASK);
  end

  assign cnt_en    = src[sel];
  assign ctl_rdata = {5'b0, sel};

endmodule

// File: rtl/tmr_cntclk_sel_chk.sv
module tmr_cntclk_sel_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       run,
  input logic       ctl_wr,
  input logic       bit_wr,
  input logic [2:0] bit_idx,
  input logic [7:0] ctl_rdata,
  input logic       cfg_err,
  input logic       cnt_en
);

  wire lock_try = run && (ctl_wr || (bit_wr && bit_idx < 3'd3));

  assert_resv_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_rdata[7:3] == 5'b0);

  assert_locked_sel_R4: assert property (@(posedge clk) disable iff (!rst_n)
    lock_try |=> $stable(ctl_rdata));

  assert_err_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
    lock_try |=> cfg_err);

  assert_err_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |=> cfg_err);

  assert_fall_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_rdata[2:0] == 3'b000 && cnt_en) |=> !(cnt_en && ctl_rdata[2:0] == 3'b000));

  assert_rise_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_rdata[2:0] == 3'b001 && cnt_en) |=> !(cnt_en && ctl_rdata[2:0] == 3'b001));

  assert_half_rate_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_rdata[2:0] == 3'b011 && cnt_en) |=> !(cnt_en && ctl_rdata[2:0] == 3'b011));

  assert_tap_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_rdata[2] && cnt_en) |=> !(cnt_en && $stable(ctl_rdata)));

endmodule

bind tmr_cntclk_sel tmr_cntclk_sel_chk u_chk (
  .clk(clk), .rst_n(rst_n), .run(run), .ctl_wr(ctl_wr), .bit_wr(bit_wr),
  .bit_idx(bit_idx), .ctl_rdata(ctl_rdata), .cfg_err(cfg_err), .cnt_en(cnt_en)
);

// File: tb/tmr_cntclk_sel_tb.sv
module tmr_cntclk_sel_tb;
  localparam int PW = 10;
  localparam int L4 = 2, L5 = 5, L6 = 7, L7 = 10;
  localparam int LGS [6] = '{0, 1, L4, L5, L6, L7};

  logic clk = 0, rst_n = 0, run = 0, ctl_wr = 0, bit_wr = 0, bit_val = 0, evt_in = 0;
  logic [7:0] ctl_wdata = 0;
  logic [2:0] bit_idx = 0;
  logic [7:0] ctl_rdata;
  logic cfg_err, cnt_en;
  int checks = 0, errors = 0;
  int pc, run_len, max_run;
  bit done = 0;

  always #4 clk = ~clk;

  tmr_cntclk_sel #(.PRE_W(PW), .LG_D4(L4), .LG_D5(L5), .LG_D6(L6), .LG_D7(L7)) u_dut (
    .clk(clk), .rst_n(rst_n), .run(run), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
    .bit_wr(bit_wr), .bit_idx(bit_idx), .bit_val(bit_val), .evt_in(evt_in),
    .ctl_rdata(ctl_rdata), .cfg_err(cfg_err), .cnt_en(cnt_en));

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic wr_byte(input logic [7:0] d);
    @(negedge clk); ctl_wr = 1; ctl_wdata = d;
    @(negedge clk); ctl_wr = 0;
  endtask

  task automatic wr_bit(input int i, input logic v);
    @(negedge clk); bit_wr = 1; bit_idx = 3'(i); bit_val = v;
    @(negedge clk); bit_wr = 0;
  endtask

  task automatic step();
    @(negedge clk);
    if (cnt_en) begin pc++; run_len++; if (run_len > max_run) max_run = run_len; end
    else run_len = 0;
  endtask

  task automatic clr();
    pc = 0; run_len = 0; max_run = 0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
  endtask

  task automatic edge_burst(input string tag);
    clr();
    for (int e = 0; e < 5; e++) begin
      evt_in = 1; repeat (4) step();
      evt_in = 0; repeat (4) step();
    end
    repeat (6) step();
    chk({tag, " pulses"}, pc, 5);
    chk({tag, " width"}, max_run, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    chk("R1 rdata", int'(ctl_rdata), 0);
    chk("R1 err", int'(cfg_err), 0);
    chk("R1 cnt_en", int'(cnt_en), 0);

    // R5 default falling-edge source, exact latency
    evt_in = 1; repeat (6) @(negedge clk);
    evt_in = 0;
    @(negedge clk); chk("R5 lat edge+1", int'(cnt_en), 0);
    @(negedge clk); chk("R5 lat edge+2", int'(cnt_en), 1);
    @(negedge clk); chk("R5 lat edge+3", int'(cnt_en), 0);
    repeat (4) @(negedge clk);
    edge_burst("R5");

    // R6 rising edge source
    wr_byte(8'h01);
    repeat (4) @(negedge clk);
    evt_in = 1;
    @(negedge clk); chk("R6 lat edge+1", int'(cnt_en), 0);
    @(negedge clk); chk("R6 lat edge+2", int'(cnt_en), 1);
    @(negedge clk); chk("R6 lat edge+3", int'(cnt_en), 0);
    evt_in = 0; repeat (4) @(negedge clk);
    edge_burst("R6");

    // R2 exhaustive byte writes
    for (int d = 0; d < 256; d++) begin
      wr_byte(8'(d));
      chk("R2 byte", int'(ctl_rdata), d & 7);
    end

    // R3 exhaustive bit writes
    for (int s = 0; s < 8; s++)
      for (int i = 0; i < 8; i++)
        for (int v = 0; v < 2; v++) begin
          int exp;
          wr_byte(8'(s));
          wr_bit(i, v[0]);
          exp = (i < 3) ? (v ? (s | (1 << i)) : (s & ~(1 << i))) : s;
          chk("R3 bit", int'(ctl_rdata), exp);
        end

    // R10 byte write wins
    wr_byte(8'h00);
    @(negedge clk); ctl_wr = 1; ctl_wdata = 8'h04; bit_wr = 1; bit_idx = 3'd0; bit_val = 1;
    @(negedge clk); ctl_wr = 0; bit_wr = 0;
    chk("R10 precedence", int'(ctl_rdata), 4);

    // R7/R8 internal taps over three full periods
    for (int s = 2; s < 8; s++) begin
      int per;
      per = 1 << LGS[s-2];
      wr_byte(8'(s));
      clr();
      repeat (3 * per) step();
      chk((s < 4) ? "R7 count" : "R8 count", pc, 3);
      chk("R9 width", max_run, (per == 1) ? 3 : 1);
      clr();
      repeat (5 * per) step();
      chk((s < 4) ? "R7 count5" : "R8 count5", pc, 5);
    end

    // R4 lock while running
    wr_byte(8'h07);
    chk("R4 pre err", int'(cfg_err), 0);
    @(negedge clk); run = 1;
    wr_bit(4, 1'b1);
    chk("R4 resv bit err", int'(cfg_err), 0);
    chk("R4 resv bit data", int'(ctl_rdata), 7);
    wr_byte(8'h00);
    chk("R4 byte ignored", int'(ctl_rdata), 7);
    chk("R4 byte err", int'(cfg_err), 1);
    wr_bit(0, 1'b0);
    chk("R4 bit ignored", int'(ctl_rdata), 7);
    @(negedge clk); run = 0;
    @(negedge clk); chk("R4 sticky", int'(cfg_err), 1);
    wr_byte(8'h01);
    chk("R4 unlock write", int'(ctl_rdata), 1);
    chk("R4 still sticky", int'(cfg_err), 1);

    do_reset();
    chk("R1 err cleared", int'(cfg_err), 0);
    chk("R1 rdata again", int'(ctl_rdata), 0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(negedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog R1 act=%0d exp=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule